// File: doc/BRIEF.md
# Adaptive Mesh Route Selector

This block is the route computation stage for one input of a two-dimensional mesh router. A head flit arrives with the router's own coordinates and the coordinates of the message's destination. One clock edge later the block returns two things: the output direction (local, east, west, north or south) and the set of output virtual channels the flit is allowed to request. Each router port carries four virtual channels. Neighbouring routers are joined by a pair of opposite one-way links.

When nothing is blocking the flit, it travels along the X axis until it reaches the destination column, and then along the Y axis. If the flit was stalled in the previous cycle, the block takes the previously chosen port into account. When both axes still bring the flit closer, the block switches to the other productive direction. The block never picks a direction that moves the flit away from its destination.

To keep adaptive routing free of deadlock, the highest-numbered virtual channel on north and south links acts as an escape channel. A flit may use it only when it is already in its destination column. The virtual channel allocator, the switch allocator, the buffers and the crossbar sit outside this block.

Top module: `mesh_route_select`

## Requirements
- R1: While reset is asserted, and for two clock edges after `rst_n` is released, `out_valid` is 0, `out_port` is 0 (local) and `out_vc_mask` is 0.
- R2: The inputs are sampled on a rising edge where `in_valid` is 1. `out_valid` is 1 after that edge, and the chosen port and mask for those inputs appear on the outputs after the same edge.
- R3: When the current and destination coordinates are equal, the port is local (code 0) and the mask is all ones (4'b1111).
- R4: When the X coordinates differ and the stall rule does not apply, the port is east (code 1) if `dst_x > cur_x`, and west (code 2) otherwise.
- R5: When the X coordinates match and the Y coordinates differ, the port is north (code 3) if `dst_y > cur_y`, and south (code 4) otherwise.
- R6: The stall rule applies when both axes are productive and `stalled` is 1. If `prev_port` equals the productive X port, the productive Y port is chosen. If `prev_port` equals the productive Y port, the productive X port is chosen. For any other `prev_port` value, R4 applies.
- R7: When only one axis is productive, `stalled` and `prev_port` have no effect on the chosen port.
- R8: The chosen port always reduces the Manhattan distance to the destination, or is local only at the destination.
- R9: On east and west ports, all four virtual channels are eligible (4'b1111).
- R10: On north and south ports, bit 3 (the escape channel) is set only if `cur_x == dst_x`. Otherwise the mask is 4'b0111.
- R11: A rising edge where `in_valid` is 0 leaves `out_valid`, `out_port` and `out_vc_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A head flit's coordinates are present this cycle |
| cur_x | input | COORD_W | X coordinate of this router |
| cur_y | input | COORD_W | Y coordinate of this router |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| stalled | input | 1 | The flit failed to advance in the previous cycle |
| prev_port | input | 3 | Port chosen on the previous attempt (0 local, 1 east, 2 west, 3 north, 4 south) |
| out_valid | output | 1 | A route result is held on the outputs |
| out_port | output | 3 | Chosen output port, same coding as `prev_port` |
| out_vc_mask | output | NUM_VC | Bit v set means virtual channel v may be requested |

## Verification
Every result is registered, so the port and mask for inputs presented before a rising edge are due right after that edge. The one exception is the two edges that follow the release of reset, when the internal reset synchronizer still holds the result registers clear. The bench drives inputs on the falling edge. A behavioural reference model updates its expected outputs on the rising edge. The bench compares the outputs on the next falling edge, so each check lands exactly one edge after its stimulus. Cycles with `in_valid` low are compared the same way, which exposes any output that moves when it should hold.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef struct packed {
    logic need_x;
    logic go_east;
    logic need_y;
    logic go_north;
  } hop_t;

endpackage

// File: rtl/rsel_hop_cmp.sv
module rsel_hop_cmp
  import rsel_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output hop_t               hop
);

  always_comb begin
    hop.need_x   = (cur_x != dst_x);
    hop.go_east  = (dst_x > cur_x);
    hop.need_y   = (cur_y != dst_y);
    hop.go_north = (dst_y > cur_y);
  end

endmodule

// File: rtl/rsel_port_pick.sv
module rsel_port_pick
  import rsel_pkg::*;
(
  input  hop_t       hop,
  input  logic       stalled,
  input  logic [2:0] prev_port,
  output port_e      port
);

  port_e x_port;
  port_e y_port;

  always_comb begin
    x_port = hop.go_east  ? PORT_EAST  : PORT_WEST;
    y_port = hop.go_north ? PORT_NORTH : PORT_SOUTH;
    if (!hop.need_x && !hop.need_y) begin
      port = PORT_LOCAL;
    end else if (hop.need_x && hop.need_y) begin
      // Both axes productive: a stall flips away from the previous try.
      if (stalled && (prev_port == x_port)) begin
        port = y_port;
      end else begin
        port = x_port;
      end
    end else if (hop.need_x) begin
      port = x_port;
    end else begin
      port = y_port;
    end
  end

endmodule

// File: rtl/rsel_vc_elig.sv
module rsel_vc_elig
  import rsel_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  port_e             port,
  input  logic              need_x,
  output logic [NUM_VC-1:0] mask
);

  localparam int ESC_VC = NUM_VC - 1;

  logic vertical;
  logic is_local;

  always_comb begin
    vertical = (port == PORT_NORTH) || (port == PORT_SOUTH);
    is_local = (port == PORT_LOCAL);
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    if (v == ESC_VC) begin : g_esc
      assign mask[v] = is_local || !(vertical && need_x);
    end else begin : g_adp
      assign mask[v] = 1'b1;
    end
  end

endmodule

// File: rtl/mesh_route_select.sv
module mesh_route_select
  import rsel_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int NUM_VC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic               stalled,
  input  logic [2:0]         prev_port,
  output logic               out_valid,
  output logic [2:0]         out_port,
  output logic [NUM_VC-1:0]  out_vc_mask
);

  localparam int ESC_VC = NUM_VC - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  hop_t              hop;
  port_e             pick;
  logic [NUM_VC-1:0] mask;

  rsel_hop_cmp #(.COORD_W(COORD_W)) u_cmp (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y), .hop(hop)
  );

  rsel_port_pick u_pick (
    .hop(hop), .stalled(stalled), .prev_port(prev_port), .port(pick)
  );

  rsel_vc_elig #(.NUM_VC(NUM_VC)) u_elig (
    .port(pick), .need_x(hop.need_x), .mask(mask)
  );

  logic              valid_d;
  logic [2:0]        port_d;
  logic [NUM_VC-1:0] mask_d;
  logic              load_en;

  always_comb begin
    load_en = in_valid;
    valid_d = out_valid;
    port_d  = out_port;
    mask_d  = out_vc_mask;
    if (load_en) begin
      valid_d = 1'b1;
      port_d  = pick;
      mask_d  = mask;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid   <= 1'b0;
      out_port    <= 3'd0;
      out_vc_mask <= '0;
    end else begin
      out_valid   <= valid_d;
      out_port    <= port_d;
      out_vc_mask <= mask_d;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(out_valid) && $stable(out_port) && $stable(out_vc_mask));

  assert_local_at_dest_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && cur_x == dst_x && cur_y == dst_y)
      |=> (out_port == 3'd0) && (&out_vc_mask));

  assert_x_first_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !stalled && cur_x != dst_x)
      |=> (out_port == 3'd1) || (out_port == 3'd2));

  assert_horiz_mask_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (out_port == 3'd1 || out_port == 3'd2)) |-> (&out_vc_mask));

  assert_escape_guard_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && cur_x != dst_x)
      |=> !((out_port == 3'd3 || out_port == 3'd4) && out_vc_mask[ESC_VC]));

  assert_no_idle_port_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (out_port <= 3'd4));

endmodule

// File: tb/mesh_route_select_tb.sv
module mesh_route_select_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] cur_x, cur_y, dst_x, dst_y;
  logic       stalled;
  logic [2:0] prev_port;
  logic       out_valid;
  logic [2:0] out_port;
  logic [3:0] out_vc_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  mesh_route_select u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .stalled(stalled), .prev_port(prev_port),
    .out_valid(out_valid), .out_port(out_port), .out_vc_mask(out_vc_mask)
  );

  // Reference model
  int    e_valid, e_port, e_mask, rel_cnt;
  string e_tag;

  always @(posedge clk) begin
    int dx, dy, hp, vp, p, m;
    string t;
    if (!rst_n || rel_cnt < 2) begin
      if (!rst_n) rel_cnt = 0; else rel_cnt = rel_cnt + 1;
      e_valid = 0; e_port = 0; e_mask = 0; e_tag = "R1";
    end else if (in_valid) begin
      dx = int'(dst_x) - int'(cur_x);
      dy = int'(dst_y) - int'(cur_y);
      hp = (dx > 0) ? 1 : 2;
      vp = (dy > 0) ? 3 : 4;
      if (dx == 0 && dy == 0) begin p = 0; t = "R3"; end
      else if (dx != 0 && dy != 0) begin
        if (stalled && prev_port == 3'(hp))      begin p = vp; t = "R6"; end
        else if (stalled && prev_port == 3'(vp)) begin p = hp; t = "R6"; end
        else                                     begin p = hp; t = "R4"; end
      end else if (dx != 0) begin p = hp; t = stalled ? "R7" : "R4"; end
      else begin p = vp; t = stalled ? "R7" : "R5"; end
      m = ((p == 3 || p == 4) && dx != 0) ? 7 : 15;
      if (m == 7) t = {t, "/R10"};
      else if (p == 1 || p == 2) t = {t, "/R9"};
      e_valid = 1; e_port = p; e_mask = m; e_tag = {t, "/R2/R8"};
    end else begin
      e_tag = "R11";
    end
  end

  task automatic compare();
    total++;
    if (out_valid !== 1'(e_valid) || out_port !== 3'(e_port) || out_vc_mask !== 4'(e_mask)) begin
      bad++;
      $display("FAIL %s: got valid=%0d port=%0d mask=%b expected valid=%0d port=%0d mask=%b",
               e_tag, out_valid, out_port, out_vc_mask, e_valid, e_port, 4'(e_mask));
    end
  endtask

  task automatic step(input logic v, input int cx, input int cy, input int tx, input int ty,
                      input logic st, input int pp);
    in_valid  = v;
    cur_x     = 4'(cx); cur_y = 4'(cy);
    dst_x     = 4'(tx); dst_y = 4'(ty);
    stalled   = st;
    prev_port = 3'(pp);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    rel_cnt = 0;
    rst_n = 1'b0;
    step(1, 1, 1, 5, 5, 0, 0);   // R1: held in reset
    step(1, 1, 1, 5, 5, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 2, 2, 6, 6, 0, 0);   // R1: synchronizer edges
    step(1, 2, 2, 6, 6, 0, 0);
    step(1, 3, 3, 3, 3, 0, 0);   // R3 local
    step(1, 1, 2, 5, 2, 0, 0);   // R4 east
    step(1, 5, 2, 1, 2, 0, 0);   // R4 west
    step(1, 4, 4, 4, 9, 0, 0);   // R5 north, full mask
    step(1, 4, 9, 4, 1, 0, 0);   // R5 south
    step(1, 1, 1, 5, 5, 1, 1);   // R6 east -> north, R10 restricted
    step(1, 5, 5, 1, 1, 1, 4);   // R6 south -> west
    step(1, 5, 5, 1, 1, 1, 2);   // R6 west -> south
    step(1, 1, 1, 5, 5, 1, 0);   // R6 other prev -> east
    step(1, 2, 2, 2, 8, 1, 3);   // R7 only north
    step(1, 2, 2, 7, 2, 1, 1);   // R7 only east
    step(1, 1, 1, 5, 5, 0, 1);   // R4 no stall
    step(0, 9, 9, 0, 0, 1, 2);   // R11 hold
    step(0, 0, 0, 15, 15, 0, 0); // R11 hold
    step(1, 0, 0, 15, 15, 0, 0); // R4 corner
    step(1, 15, 15, 15, 0, 1, 4);// R7 south corner
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 16, $urandom % 16,
           $urandom % 16, $urandom % 2, $urandom % 5);
    end
    rst_n = 1'b0;                // R1: reset again mid-run
    step(1, 1, 1, 5, 5, 0, 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule